// File: doc/BRIEF.md
# Selector Privilege Raise Unit

This execution unit carries out the instruction that raises the two-bit requested-privilege field held in the low bits of a 16-bit segment selector. It takes one decoded request from the front end. The request carries the opcode byte, the ModRM byte, the processor mode, the LOCK prefix flag and the current privilege level. It also carries the value of the source word register, the value of the destination register, and the outcome of the segment checks that address generation has already made. The unit first decides whether the request is legal in the current mode. If it is, the unit compares the two privilege fields. When the destination field is lower, the unit copies the source field into the destination and sets the zero flag. Otherwise it clears the zero flag and leaves the destination alone.

A register destination (ModRM mod field equal to 3) completes in the cycle after acceptance. A memory destination goes through a read, a compare, an optional write and a completion step on a simple memory port. On that port the unit holds `mem_valid` and every request field steady until the memory raises `mem_ready`. A transfer completes in any cycle where both are high, and the read data and the page-fault flag are sampled in that cycle. The request input is a valid/ready stream: `req_ready` is high only while the unit is idle, and a request is taken on a cycle with both high. The completion pulse `done` lasts one cycle and cannot be back-pressured. It carries either a result or an exception code.

Top module: `selpriv_adjust_unit`

## Requirements
- R1: When destination bits 1:0 are numerically below source bits 1:0, the result word is destination bits 15:2 joined with source bits 1:0, `res_zf` is 1 and `res_flag_we` is 1.
- R2: When destination bits 1:0 are equal to or above source bits 1:0, `res_zf` is 0, `res_flag_we` is 1, `res_reg_we` is 0, the reported word equals the destination, and no memory write is issued.
- R3: A register destination (ModRM bits 7:6 = 3) completes with `done` in the first cycle after acceptance, and no memory access is made. `res_reg_we` is 1 only when the word changed, and `res_reg_idx` equals ModRM bits 2:0.
- R4: In 64-bit mode (`req_mode` = 3) the request completes with `res_redirect` = 1, exception code 0, both write enables 0 and no memory access. This takes precedence over every other check, including LOCK.
- R5: In real mode (`req_mode` = 0) and virtual-8086 mode (`req_mode` = 1) the request completes with exception code 1 (invalid opcode).
- R6: In protected mode (`req_mode` = 2), a LOCK prefix gives exception code 1 before any memory access starts, even when a segment fault is also reported.
- R7: An opcode byte other than 0x63 gives exception code 1.
- R8: For a memory destination, a limit fault gives code 3 (stack fault) when `req_stack_seg` is 1 and code 2 (general protection) otherwise. A non-writable segment gives code 2. The limit fault is checked first, and none of these cases touches memory.
- R9: Code 5 (alignment) is raised when alignment checking is on, the access is unaligned and the privilege level is 3. At privilege level 0 the same access executes normally.
- R10: A page fault reported on the read or the write transfer gives code 4 (page fault). The zero flag and the destination are then not updated.
- R11: A memory destination issues exactly one read and then one write of the merged word, and the write is issued only when the field is raised. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write` and `mem_wdata` hold their values.
- R12: `req_ready` is high only while idle, each accepted request produces one single-cycle `done`, and any exception leaves `res_flag_we` and `res_reg_we` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_opcode | input | 8 | Opcode byte |
| req_modrm | input | 8 | ModRM byte |
| req_mode | input | 2 | 0 real, 1 virtual-8086, 2 protected/compatibility, 3 64-bit |
| req_lock | input | 1 | LOCK prefix present |
| req_cpl | input | 2 | Current privilege level |
| req_src | input | 16 | Source register value |
| req_dst | input | 16 | Destination register value (register form) |
| req_seg_wr_ok | input | 1 | Destination segment is writable |
| req_lim_fault | input | 1 | Effective address outside segment limit |
| req_stack_seg | input | 1 | Access goes through the stack segment |
| req_align_chk | input | 1 | Alignment checking enabled |
| req_unaligned | input | 1 | Effective address not word aligned |
| mem_valid | output | 1 | Memory transfer request |
| mem_write | output | 1 | 1 write, 0 read |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_pf | input | 1 | Page fault, valid with mem_ready |
| done | output | 1 | One-cycle completion pulse |
| res_word | output | 16 | Resulting destination word |
| res_zf | output | 1 | New zero flag |
| res_flag_we | output | 1 | Zero flag must be written |
| res_reg_we | output | 1 | Destination register must be written |
| res_reg_idx | output | 3 | Destination register number |
| res_exc | output | 3 | 0 none, 1 invalid opcode, 2 general protection, 3 stack, 4 page, 5 alignment |
| res_redirect | output | 1 | Opcode belongs to another instruction in this mode |

## Verification
Two cases can occur on the same request or in the same cycle. In the first, a LOCK prefix arrives together with a segment limit fault on a memory destination. The bench raises both inputs on one request and accepts the result only if it shows the invalid-opcode code and zero memory transfers. In the second, a page fault is reported in the same cycle as the write handshake. The bench signals the fault on that handshake and requires the page-fault code, no flag write, and the memory word left at its old value. Back-pressure is applied with several memory latencies, and the result must not depend on them.

// File: rtl/selpriv_pkg.sv
package selpriv_pkg;

  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_UD    = 3'd1,
    EXC_GP    = 3'd2,
    EXC_SS    = 3'd3,
    EXC_PF    = 3'd4,
    EXC_AC    = 3'd5
  } exc_e;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_V86  = 2'd1,
    MODE_PROT = 2'd2,
    MODE_LONG = 2'd3
  } cpu_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_COMPARE,
    ST_WRITE,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic redirect;
    exc_e exc;
    logic mem_dst;
  } gate_t;

endpackage

// File: rtl/selpriv_gate.sv
module selpriv_gate
  import selpriv_pkg::*;
#(
  parameter int          CPL_W  = 2,
  parameter logic [7:0]  OPCODE = 8'h63
) (
  input  logic [7:0]       opcode,
  input  logic [1:0]       modrm_mod,
  input  logic [1:0]       mode,
  input  logic             lock,
  input  logic [CPL_W-1:0] cpl,
  input  logic             seg_wr_ok,
  input  logic             lim_fault,
  input  logic             stack_seg,
  input  logic             align_chk,
  input  logic             unaligned,
  output gate_t            verdict
);

  localparam logic [CPL_W-1:0] USER_LVL = '1;

  logic mem_dst;
  assign mem_dst = (modrm_mod != 2'b11);

  always_comb begin
    verdict.redirect = 1'b0;
    verdict.exc      = EXC_NONE;
    verdict.mem_dst  = mem_dst;
    if (mode == MODE_LONG) begin
      verdict.redirect = 1'b1;
    end else if (mode == MODE_REAL || mode == MODE_V86) begin
      verdict.exc = EXC_UD;
    end else if (lock) begin
      verdict.exc = EXC_UD;
    end else if (opcode != OPCODE) begin
      verdict.exc = EXC_UD;
    end else if (mem_dst) begin
      if (lim_fault)
        verdict.exc = stack_seg ? EXC_SS : EXC_GP;
      else if (!seg_wr_ok)
        verdict.exc = EXC_GP;
      else if (align_chk && unaligned && cpl == USER_LVL)
        verdict.exc = EXC_AC;
    end
  end

endmodule

// File: rtl/selpriv_merge.sv
module selpriv_merge #(
  parameter int WORD_W  = 16,
  parameter int FIELD_W = 2
) (
  input  logic [WORD_W-1:0] dst,
  input  logic [WORD_W-1:0] src,
  output logic [WORD_W-1:0] merged,
  output logic              raise
);

  localparam int HI_W = WORD_W - FIELD_W;

  logic [FIELD_W-1:0] dst_fld, src_fld;
  logic [HI_W-1:0]    dst_hi;

  assign dst_fld = dst[FIELD_W-1:0];
  assign src_fld = src[FIELD_W-1:0];
  assign dst_hi  = dst[WORD_W-1:FIELD_W];
  assign raise   = (dst_fld < src_fld);
  assign merged  = raise ? {dst_hi, src_fld} : dst;

  logic unused_src_hi;
  assign unused_src_hi = ^src[WORD_W-1:FIELD_W];

endmodule

// File: rtl/selpriv_adjust_unit.sv
module selpriv_adjust_unit
  import selpriv_pkg::*;
#(
  parameter int          WORD_W  = 16,
  parameter int          FIELD_W = 2,
  parameter int          CPL_W   = 2,
  parameter logic [7:0]  OPCODE  = 8'h63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic [7:0]        req_modrm,
  input  logic [1:0]        req_mode,
  input  logic              req_lock,
  input  logic [CPL_W-1:0]  req_cpl,
  input  logic [WORD_W-1:0] req_src,
  input  logic [WORD_W-1:0] req_dst,
  input  logic              req_seg_wr_ok,
  input  logic              req_lim_fault,
  input  logic              req_stack_seg,
  input  logic              req_align_chk,
  input  logic              req_unaligned,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_pf,
  output logic              done,
  output logic [WORD_W-1:0] res_word,
  output logic              res_zf,
  output logic              res_flag_we,
  output logic              res_reg_we,
  output logic [2:0]        res_reg_idx,
  output logic [2:0]        res_exc,
  output logic              res_redirect
);

  state_e            st;
  gate_t             verdict;
  exc_e              exc_q;
  logic              redir_q, zf_q, flag_we_q, reg_we_q;
  logic [WORD_W-1:0] word_q, dst_q, src_q;
  logic [2:0]        idx_q;
  logic [WORD_W-1:0] m_dst, m_src, m_word;
  logic              m_raise, accept;

  logic unused_reg_fld;
  assign unused_reg_fld = ^req_modrm[5:3];

  selpriv_gate #(.CPL_W(CPL_W), .OPCODE(OPCODE)) u_gate (
    .opcode    (req_opcode),
    .modrm_mod (req_modrm[7:6]),
    .mode      (req_mode),
    .lock      (req_lock),
    .cpl       (req_cpl),
    .seg_wr_ok (req_seg_wr_ok),
    .lim_fault (req_lim_fault),
    .stack_seg (req_stack_seg),
    .align_chk (req_align_chk),
    .unaligned (req_unaligned),
    .verdict   (verdict)
  );

  // one comparator shared: register form at acceptance, memory form in COMPARE
  assign m_dst = (st == ST_COMPARE) ? dst_q : req_dst;
  assign m_src = (st == ST_COMPARE) ? src_q : req_src;

  selpriv_merge #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_merge (
    .dst    (m_dst),
    .src    (m_src),
    .merged (m_word),
    .raise  (m_raise)
  );

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      exc_q     <= EXC_NONE;
      redir_q   <= 1'b0;
      zf_q      <= 1'b0;
      flag_we_q <= 1'b0;
      reg_we_q  <= 1'b0;
      word_q    <= '0;
      dst_q     <= '0;
      src_q     <= '0;
      idx_q     <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            src_q     <= req_src;
            idx_q     <= req_modrm[2:0];
            exc_q     <= verdict.exc;
            redir_q   <= verdict.redirect;
            zf_q      <= 1'b0;
            flag_we_q <= 1'b0;
            reg_we_q  <= 1'b0;
            word_q    <= req_dst;
            if (verdict.redirect || verdict.exc != EXC_NONE) begin
              st <= ST_DONE;
            end else if (!verdict.mem_dst) begin
              word_q    <= m_word;
              zf_q      <= m_raise;
              flag_we_q <= 1'b1;
              reg_we_q  <= m_raise;
              st        <= ST_DONE;
            end else begin
              st <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (mem_ready) begin
            if (mem_pf) begin
              exc_q <= EXC_PF;
              st    <= ST_DONE;
            end else begin
              dst_q <= mem_rdata;
              st    <= ST_COMPARE;
            end
          end
        end
        ST_COMPARE: begin
          word_q <= m_word;
          zf_q   <= m_raise;
          if (m_raise) begin
            st <= ST_WRITE;
          end else begin
            flag_we_q <= 1'b1;
            st        <= ST_DONE;
          end
        end
        ST_WRITE: begin
          if (mem_ready) begin
            if (mem_pf) begin
              exc_q <= EXC_PF;
              zf_q  <= 1'b0;
              word_q <= dst_q;
            end else begin
              flag_we_q <= 1'b1;
            end
            st <= ST_DONE;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid    = (st == ST_READ) || (st == ST_WRITE);
  assign mem_write    = (st == ST_WRITE);
  assign mem_wdata    = word_q;
  assign done         = (st == ST_DONE);
  assign res_word     = word_q;
  assign res_zf       = zf_q;
  assign res_flag_we  = flag_we_q;
  assign res_reg_we   = reg_we_q;
  assign res_reg_idx  = idx_q;
  assign res_exc      = exc_q;
  assign res_redirect = redir_q;

endmodule

// File: rtl/selpriv_adjust_unit_sva.sv
module selpriv_adjust_unit_sva #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_mode,
  input logic              req_lock,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              done,
  input logic              res_zf,
  input logic              res_flag_we,
  input logic              res_reg_we,
  input logic [2:0]        res_exc,
  input logic              res_redirect
);

  assert_zf_with_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_reg_we |-> res_zf && res_flag_we);

  assert_clear_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_flag_we && !res_zf |-> !res_reg_we);

  assert_long_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_mode == 2'd3 |=>
      done && res_redirect && res_exc == 3'd0 && !res_flag_we && !res_reg_we);

  assert_legacy_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_mode == 2'd0 || req_mode == 2'd1) |=>
      done && res_exc == 3'd1);

  assert_lock_before_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_lock && req_mode == 2'd2 |=>
      done && !mem_valid && res_exc == 3'd1);

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_write) && $stable(mem_wdata));

  assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fault_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_exc != 3'd0 |-> !res_flag_we && !res_reg_we);

endmodule

bind selpriv_adjust_unit selpriv_adjust_unit_sva #(.WORD_W(WORD_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_mode     (req_mode),
  .req_lock     (req_lock),
  .mem_valid    (mem_valid),
  .mem_ready    (mem_ready),
  .mem_write    (mem_write),
  .mem_wdata    (mem_wdata),
  .done         (done),
  .res_zf       (res_zf),
  .res_flag_we  (res_flag_we),
  .res_reg_we   (res_reg_we),
  .res_exc      (res_exc),
  .res_redirect (res_redirect)
);

// File: tb/selpriv_adjust_unit_tb.sv
`timescale 1ns/100ps
module selpriv_adjust_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_opcode = 8'h63;
  logic [7:0]  req_modrm = 8'hC1;
  logic [1:0]  req_mode = 2'd2;
  logic        req_lock = 1'b0;
  logic [1:0]  req_cpl = 2'd0;
  logic [15:0] req_src = '0;
  logic [15:0] req_dst = '0;
  logic        req_seg_wr_ok = 1'b1;
  logic        req_lim_fault = 1'b0;
  logic        req_stack_seg = 1'b0;
  logic        req_align_chk = 1'b0;
  logic        req_unaligned = 1'b0;
  logic        mem_valid, mem_write, mem_ready, mem_pf;
  logic [15:0] mem_wdata, mem_rdata;
  logic        done, res_zf, res_flag_we, res_reg_we, res_redirect;
  logic [15:0] res_word;
  logic [2:0]  res_reg_idx, res_exc;

  // bench memory model
  logic [15:0] mem_word = '0;
  int          mem_lat = 0;
  int          wait_cnt = 0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic        pf_rd = 1'b0;
  logic        pf_wr = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  assign mem_ready = mem_valid && (wait_cnt >= mem_lat);
  assign mem_rdata = mem_word;
  assign mem_pf    = mem_valid && (mem_write ? pf_wr : pf_rd);

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      wait_cnt <= 0;
      if (mem_write) begin
        wr_cnt <= wr_cnt + 1;
        if (!pf_wr) mem_word <= mem_wdata;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end else if (mem_valid) begin
      wait_cnt <= wait_cnt + 1;
    end
  end

  selpriv_adjust_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_modrm(req_modrm), .req_mode(req_mode),
    .req_lock(req_lock), .req_cpl(req_cpl), .req_src(req_src), .req_dst(req_dst),
    .req_seg_wr_ok(req_seg_wr_ok), .req_lim_fault(req_lim_fault),
    .req_stack_seg(req_stack_seg), .req_align_chk(req_align_chk),
    .req_unaligned(req_unaligned),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_pf(mem_pf),
    .done(done), .res_word(res_word), .res_zf(res_zf), .res_flag_we(res_flag_we),
    .res_reg_we(res_reg_we), .res_reg_idx(res_reg_idx), .res_exc(res_exc),
    .res_redirect(res_redirect)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        lock;
    logic [7:0]  op;
    logic [15:0] src;
    logic [15:0] dst;
    logic [2:0]  exc;
    logic        redir;
    logic        zf;
    logic        we;
    logic [15:0] word;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 1'b0, 8'h63, 16'h0003, 16'h1234, 3'd0, 1'b0, 1'b1, 1'b1, 16'h1237},
    '{2'd2, 1'b0, 8'h63, 16'h0001, 16'hABCE, 3'd0, 1'b0, 1'b0, 1'b0, 16'hABCE},
    '{2'd2, 1'b0, 8'h63, 16'h0002, 16'h0F0A, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0F0A},
    '{2'd2, 1'b0, 8'h63, 16'hFFFE, 16'h8001, 3'd0, 1'b0, 1'b1, 1'b1, 16'h8002},
    '{2'd2, 1'b0, 8'h63, 16'h0000, 16'hFFFF, 3'd0, 1'b0, 1'b0, 1'b0, 16'hFFFF},
    '{2'd0, 1'b0, 8'h63, 16'h0003, 16'h0000, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{2'd1, 1'b0, 8'h63, 16'h0003, 16'h0000, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{2'd3, 1'b0, 8'h63, 16'h0003, 16'h0000, 3'd0, 1'b1, 1'b0, 1'b0, 16'h0000},
    '{2'd2, 1'b1, 8'h63, 16'h0003, 16'h0000, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{2'd2, 1'b0, 8'h64, 16'h0003, 16'h0000, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{2'd3, 1'b1, 8'h63, 16'h0003, 16'h0000, 3'd0, 1'b1, 1'b0, 1'b0, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // drive one request and return at the falling edge where done is high
  task automatic issue(output int latency);
    int n;
    rd_cnt = 0;
    wr_cnt = 0;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
    end
    latency = n;
  endtask

  task automatic set_mem(input logic [15:0] src, input logic [15:0] word);
    req_opcode = 8'h63; req_modrm = 8'h07; req_mode = 2'd2; req_lock = 1'b0;
    req_cpl = 2'd0; req_src = src; req_dst = 16'h0000; req_seg_wr_ok = 1'b1;
    req_lim_fault = 1'b0; req_stack_seg = 1'b0; req_align_chk = 1'b0;
    req_unaligned = 1'b0; pf_rd = 1'b0; pf_wr = 1'b0; mem_word = word;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R12 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset req_ready", {31'd0, req_ready}, 32'd1);
    check("R12 reset done", {31'd0, done}, 32'd0);
    check("R11 reset mem_valid", {31'd0, mem_valid}, 32'd0);

    // table walk: register-form destination
    for (int i = 0; i < NV; i++) begin
      req_mode = VEC[i].mode; req_lock = VEC[i].lock; req_opcode = VEC[i].op;
      req_modrm = 8'hC1; req_src = VEC[i].src; req_dst = VEC[i].dst;
      req_cpl = 2'd0; req_seg_wr_ok = 1'b1; req_lim_fault = 1'b0;
      req_align_chk = 1'b0; req_unaligned = 1'b0;
      issue(lat);
      check("R3 register latency", lat, 1);
      check("R5 R7 R6 exc code", {29'd0, res_exc}, {29'd0, VEC[i].exc});
      check("R4 redirect", {31'd0, res_redirect}, {31'd0, VEC[i].redir});
      check("R12 flag_we", {31'd0, res_flag_we},
            {31'd0, (VEC[i].exc == 3'd0 && !VEC[i].redir)});
      check("R1 R2 reg_we", {31'd0, res_reg_we}, {31'd0, VEC[i].we});
      check("R3 no memory", rd_cnt + wr_cnt, 0);
      if (VEC[i].exc == 3'd0 && !VEC[i].redir) begin
        check("R1 R2 zf", {31'd0, res_zf}, {31'd0, VEC[i].zf});
        check("R1 R2 word", {16'd0, res_word}, {16'd0, VEC[i].word});
        check("R3 reg idx", {29'd0, res_reg_idx}, 32'd1);
      end
      @(negedge clk);
      check("R12 ready after done", {31'd0, req_ready}, 32'd1);
    end

    // memory destination, raise, with back-pressure
    for (int l = 0; l < 3; l++) begin
      set_mem(16'h0003, 16'h5550);
      mem_lat = l;
      issue(lat);
      check("R11 one read", rd_cnt, 1);
      check("R11 one write", wr_cnt, 1);
      check("R1 memory word", {16'd0, mem_word}, 32'h5553);
      check("R1 memory zf", {30'd0, res_zf, res_flag_we}, 32'd3);
      check("R3 mem no reg_we", {31'd0, res_reg_we}, 32'd0);
      @(negedge clk);
    end
    mem_lat = 1;

    set_mem(16'h0001, 16'h5553);
    issue(lat);
    check("R2 memory no write", wr_cnt, 0);
    check("R2 memory zf", {29'd0, res_zf, res_flag_we, res_reg_we}, 32'd2);
    check("R2 memory word", {16'd0, mem_word}, 32'h5553);
    @(negedge clk);

    set_mem(16'h0003, 16'h0000); req_lim_fault = 1'b1;
    issue(lat);
    check("R8 limit gp", {29'd0, res_exc}, 32'd2);
    check("R8 no access", rd_cnt + wr_cnt, 0);
    @(negedge clk);

    set_mem(16'h0003, 16'h0000); req_lim_fault = 1'b1; req_stack_seg = 1'b1;
    req_seg_wr_ok = 1'b0;
    issue(lat);
    check("R8 stack limit first", {29'd0, res_exc}, 32'd3);
    @(negedge clk);

    set_mem(16'h0003, 16'h0000); req_seg_wr_ok = 1'b0;
    issue(lat);
    check("R8 not writable", {29'd0, res_exc}, 32'd2);
    check("R8 no access wr", rd_cnt + wr_cnt, 0);
    @(negedge clk);

    set_mem(16'h0003, 16'h0000); req_align_chk = 1'b1; req_unaligned = 1'b1;
    req_cpl = 2'd3;
    issue(lat);
    check("R9 align fault", {29'd0, res_exc}, 32'd5);
    check("R9 no flag", {30'd0, res_flag_we, res_reg_we}, 32'd0);
    @(negedge clk);

    set_mem(16'h0003, 16'h0000); req_align_chk = 1'b1; req_unaligned = 1'b1;
    req_cpl = 2'd0;
    issue(lat);
    check("R9 kernel executes", {29'd0, res_exc}, 32'd0);
    check("R9 kernel word", {16'd0, mem_word}, 32'h0003);
    @(negedge clk);

    set_mem(16'h0003, 16'h1110); pf_rd = 1'b1;
    issue(lat);
    check("R10 read pf", {29'd0, res_exc}, 32'd4);
    check("R10 read pf no write", wr_cnt, 0);
    check("R10 read pf flag", {31'd0, res_flag_we}, 32'd0);
    @(negedge clk);

    set_mem(16'h0003, 16'h2220); pf_wr = 1'b1;
    issue(lat);
    check("R10 write pf", {29'd0, res_exc}, 32'd4);
    check("R10 write pf flag", {30'd0, res_flag_we, res_reg_we}, 32'd0);
    check("R10 write pf memory", {16'd0, mem_word}, 32'h2220);
    @(negedge clk);

    set_mem(16'h0003, 16'h0000); req_lock = 1'b1; req_lim_fault = 1'b1;
    issue(lat);
    check("R6 lock over limit", {29'd0, res_exc}, 32'd1);
    check("R6 no access", rd_cnt + wr_cnt, 0);
    @(negedge clk);

    set_mem(16'h0003, 16'h0000); req_mode = 2'd3; req_lim_fault = 1'b1;
    issue(lat);
    check("R4 long mem redirect", {31'd0, res_redirect}, 32'd1);
    check("R4 long no access", rd_cnt + wr_cnt, 0);
    @(negedge clk);

    finish_run();
  end

endmodule